// File: doc/BRIEF.md
# Stream Command Dependency Scheduler

This block sits between a single command writer and three execution resources: one kernel unit, a load channel and a store channel. Each command names an operation (block load, block store, indexed load, indexed store, kernel), a source stream, a destination stream and a memory buffer. Accepted commands wait in slots. Loads and stores share one slot pool and kernels use a second, smaller pool. A command is sent to its resource only after every older command it conflicts with has reported completion.

Stream conflicts are read-after-write, write-after-read and write-after-write on 4-bit stream IDs. Buffer conflicts occur between two memory commands on the same buffer when at least one of them is a store. When several commands are ready, the oldest one is sent first. Each resource runs one command at a time and reports completion with a done pulse that carries the slot number. Indexed transfers never overlap one another. A block load and a block store with no conflict between them can overlap.

Top module: `stream_dep_sched`

## Requirements
- R1: After reset all slots are empty, `cmd_ready` is high for every legal opcode, and no `*_go` output is asserted. Opcodes: 0 block load, 1 block store, 2 indexed load, 3 indexed store, 4 kernel. Codes 5 to 7 are never accepted.
- R2: Loads and stores share MEM_SLOTS (12) slots. While all of them are occupied, `cmd_ready` is low for opcodes 0 to 3 and a write waits. The kernel pool of KRN_SLOTS (4) slots fills and stalls opcode 4 independently of the memory pool.
- R3: A kernel is not issued before every older load whose destination stream equals the kernel's source stream has completed.
- R4: A kernel is not issued before every older store whose source stream equals the kernel's destination stream has completed.
- R5: A store is not issued before every older kernel whose destination stream equals the store's source stream has completed.
- R6: A load is not issued before every older kernel whose source stream equals the load's destination stream has completed.
- R7: A memory command is not issued while an older memory command on the same buffer is pending or in flight, if either of the two is a store.
- R8: A block load and a block store with no conflict between them can be in flight at the same time.
- R9: At most one indexed transfer (opcode 2 or 3) is in flight at any time, counting both channels.
- R10: Each resource runs one command at a time. Among its ready commands the oldest is issued. A blocked older command does not hold back a younger one that is ready.
- R11: A done pulse with the slot number frees that slot and clears its conflicts at the same clock edge. A command that waited only on that slot, and whose resource is idle, has its `*_go` asserted exactly one cycle after the done was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write request |
| cmd_ready | output | 1 | A slot of the pool needed by `cmd_op` is free |
| cmd_op | input | 3 | Opcode (see R1) |
| cmd_src | input | ID_W | Stream read (store, kernel) |
| cmd_dst | input | ID_W | Stream written (load, kernel) |
| cmd_buf | input | ID_W | Memory buffer (loads, stores) |
| k_go | output | 1 | One-cycle kernel issue pulse |
| k_slot | output | SW | Slot of the issued kernel |
| k_src | output | ID_W | Kernel source stream |
| k_dst | output | ID_W | Kernel destination stream |
| k_done | input | 1 | Kernel completion pulse |
| k_done_slot | input | SW | Slot that completed |
| ld_go | output | 1 | One-cycle load issue pulse |
| ld_slot | output | SW | Slot of the issued load |
| ld_indexed | output | 1 | Issued load is indexed |
| ld_dst | output | ID_W | Load destination stream |
| ld_buf | output | ID_W | Load buffer |
| ld_done | input | 1 | Load completion pulse |
| ld_done_slot | input | SW | Slot that completed |
| st_go | output | 1 | One-cycle store issue pulse |
| st_slot | output | SW | Slot of the issued store |
| st_indexed | output | 1 | Issued store is indexed |
| st_src | output | ID_W | Store source stream |
| st_buf | output | ID_W | Store buffer |
| st_done | input | 1 | Store completion pulse |
| st_done_slot | input | SW | Slot that completed |

## Verification
The hardest state to reach is a full memory pool while the kernel pool is still open. The bench gets there by having its load responder hold the first issued load indefinitely, so twelve loads stay resident. It then probes `cmd_ready` for both opcode classes and leaves a thirteenth write stalled until the hold is released. Out-of-order issue is reached in a similar way: a long load keeps an older dependent kernel blocked while a younger independent kernel has to go ahead of it.

// File: rtl/sds_pkg.sv
package sds_pkg;

   typedef enum logic [2:0] {
      OP_BLK_LD = 3'd0,
      OP_BLK_ST = 3'd1,
      OP_IDX_LD = 3'd2,
      OP_IDX_ST = 3'd3,
      OP_KERNEL = 3'd4
   } sds_op_e;

   function automatic logic op_is_load(input logic [2:0] op);
      return (op == OP_BLK_LD) || (op == OP_IDX_LD);
   endfunction

   function automatic logic op_is_store(input logic [2:0] op);
      return (op == OP_BLK_ST) || (op == OP_IDX_ST);
   endfunction

   function automatic logic op_is_kern(input logic [2:0] op);
      return op == OP_KERNEL;
   endfunction

   function automatic logic op_is_mem(input logic [2:0] op);
      return op_is_load(op) || op_is_store(op);
   endfunction

   function automatic logic op_is_idx(input logic [2:0] op);
      return (op == OP_IDX_LD) || (op == OP_IDX_ST);
   endfunction

   // stream read by the command: stores and kernels
   function automatic logic op_rd_stream(input logic [2:0] op);
      return op_is_store(op) || op_is_kern(op);
   endfunction

   // stream written by the command: loads and kernels
   function automatic logic op_wr_stream(input logic [2:0] op);
      return op_is_load(op) || op_is_kern(op);
   endfunction

endpackage

// File: rtl/sds_free_find.sv
// Lowest free slot inside one pool window [BASE, BASE+CNT).
module sds_free_find #(
   parameter int CNT  = 12,
   parameter int BASE = 0,
   parameter int SW   = 4
) (
   input  logic [CNT-1:0] busy,
   output logic           found,
   output logic [SW-1:0]  idx
);
   if (CNT < 1) begin : g_bad_cnt
      $error("sds_free_find: CNT must be at least 1");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = CNT - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            found = 1'b1;
            idx   = SW'(BASE + i);
         end
      end
   end
endmodule

// File: rtl/sds_oldest.sv
// Picks the single oldest candidate. age[i][j] = 1 means slot j entered before slot i.
module sds_oldest #(
   parameter int N  = 16,
   parameter int SW = 4
) (
   input  logic [N-1:0]  cand,
   input  logic [N-1:0]  age [N],
   output logic          found,
   output logic [SW-1:0] idx
);
   logic [N-1:0] win;

   for (genvar i = 0; i < N; i++) begin : g_win
      assign win[i] = cand[i] && ((cand & age[i]) == '0);
   end

   always_comb begin
      found = |win;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (win[i]) idx = SW'(i);
      end
   end
endmodule

// File: rtl/sds_hazard.sv
// Conflict matrix: a slot is blocked while any older live slot conflicts with it.
module sds_hazard
   import sds_pkg::*;
#(
   parameter int N    = 16,
   parameter int ID_W = 4
) (
   input  logic [N-1:0]    vld,
   input  logic [2:0]      op   [N],
   input  logic [ID_W-1:0] src  [N],
   input  logic [ID_W-1:0] dst  [N],
   input  logic [ID_W-1:0] bfr  [N],
   input  logic [N-1:0]    age  [N],
   output logic [N-1:0]    blocked
);
   logic [N-1:0] conf [N];

   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         logic raw_s, war_s, waw_s, buf_c;
         // i is the younger command, j the older one
         assign raw_s = op_wr_stream(op[j]) && op_rd_stream(op[i]) && (dst[j] == src[i]);
         assign war_s = op_rd_stream(op[j]) && op_wr_stream(op[i]) && (src[j] == dst[i]);
         assign waw_s = op_wr_stream(op[j]) && op_wr_stream(op[i]) && (dst[j] == dst[i]);
         assign buf_c = op_is_mem(op[j]) && op_is_mem(op[i]) &&
                        (op_is_store(op[j]) || op_is_store(op[i])) && (bfr[j] == bfr[i]);
         assign conf[i][j] = raw_s || war_s || waw_s || buf_c;
      end
      assign blocked[i] = |(vld & age[i] & conf[i]);
   end
endmodule

// File: rtl/stream_dep_sched.sv
module stream_dep_sched
   import sds_pkg::*;
#(
   parameter int MEM_SLOTS = 12,
   parameter int KRN_SLOTS = 4,
   parameter int ID_W      = 4,
   localparam int N        = MEM_SLOTS + KRN_SLOTS,
   localparam int SW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   output logic            cmd_ready,
   input  logic [2:0]      cmd_op,
   input  logic [ID_W-1:0] cmd_src,
   input  logic [ID_W-1:0] cmd_dst,
   input  logic [ID_W-1:0] cmd_buf,
   output logic            k_go,
   output logic [SW-1:0]   k_slot,
   output logic [ID_W-1:0] k_src,
   output logic [ID_W-1:0] k_dst,
   input  logic            k_done,
   input  logic [SW-1:0]   k_done_slot,
   output logic            ld_go,
   output logic [SW-1:0]   ld_slot,
   output logic            ld_indexed,
   output logic [ID_W-1:0] ld_dst,
   output logic [ID_W-1:0] ld_buf,
   input  logic            ld_done,
   input  logic [SW-1:0]   ld_done_slot,
   output logic            st_go,
   output logic [SW-1:0]   st_slot,
   output logic            st_indexed,
   output logic [ID_W-1:0] st_src,
   output logic [ID_W-1:0] st_buf,
   input  logic            st_done,
   input  logic [SW-1:0]   st_done_slot
);
   if (MEM_SLOTS < 1 || KRN_SLOTS < 1) begin : g_bad_pool
      $error("stream_dep_sched: both slot pools need at least one slot");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("stream_dep_sched: ID_W must be at least 1");
   end

   // ---------------- slot state ----------------
   logic [N-1:0]    vld, iss;
   logic [2:0]      s_op  [N];
   logic [ID_W-1:0] s_src [N];
   logic [ID_W-1:0] s_dst [N];
   logic [ID_W-1:0] s_buf [N];
   logic [N-1:0]    age   [N];

   logic k_busy, ld_busy, st_busy, ld_busy_idx, st_busy_idx;

   // ---------------- allocation ----------------
   logic            mem_found, krn_found;
   logic [SW-1:0]   mem_free_idx, krn_free_idx, alloc_idx;
   logic            op_mem, op_krn, accept;

   sds_free_find #(.CNT(MEM_SLOTS), .BASE(0), .SW(SW)) u_mem_free (
      .busy  (vld[MEM_SLOTS-1:0]),
      .found (mem_found),
      .idx   (mem_free_idx)
   );

   sds_free_find #(.CNT(KRN_SLOTS), .BASE(MEM_SLOTS), .SW(SW)) u_krn_free (
      .busy  (vld[N-1:MEM_SLOTS]),
      .found (krn_found),
      .idx   (krn_free_idx)
   );

   assign op_mem    = op_is_mem(cmd_op);
   assign op_krn    = op_is_kern(cmd_op);
   assign cmd_ready = (op_mem && mem_found) || (op_krn && krn_found);
   assign accept    = cmd_valid && cmd_ready;
   assign alloc_idx = op_krn ? krn_free_idx : mem_free_idx;

   // ---------------- conflicts ----------------
   logic [N-1:0] blocked;

   sds_hazard #(.N(N), .ID_W(ID_W)) u_hazard (
      .vld     (vld),
      .op      (s_op),
      .src     (s_src),
      .dst     (s_dst),
      .bfr     (s_buf),
      .age     (age),
      .blocked (blocked)
   );

   // ---------------- candidates and picks ----------------
   logic          idx_busy;
   logic [N-1:0]  k_cand, ld_cand, st_cand;
   logic          k_found, ld_found, st_found;
   logic [SW-1:0] k_pick, ld_pick, st_pick;

   assign idx_busy = (ld_busy && ld_busy_idx) || (st_busy && st_busy_idx);

   always_comb begin
      for (int i = 0; i < N; i++) begin
         logic pend;
         pend       = vld[i] && !iss[i] && !blocked[i];
         k_cand[i]  = pend && op_is_kern(s_op[i]) && !k_busy;
         ld_cand[i] = pend && op_is_load(s_op[i]) && !ld_busy &&
                      !(op_is_idx(s_op[i]) && idx_busy);
         st_cand[i] = pend && op_is_store(s_op[i]) && !st_busy &&
                      !(op_is_idx(s_op[i]) && idx_busy);
      end
   end

   sds_oldest #(.N(N), .SW(SW)) u_pick_k  (.cand(k_cand),  .age(age), .found(k_found),  .idx(k_pick));
   sds_oldest #(.N(N), .SW(SW)) u_pick_ld (.cand(ld_cand), .age(age), .found(ld_found), .idx(ld_pick));
   sds_oldest #(.N(N), .SW(SW)) u_pick_st (.cand(st_cand), .age(age), .found(st_found), .idx(st_pick));

   // two indexed picks in one cycle: only the older one goes
   logic both_idx, st_is_older, k_issue, ld_issue, st_issue;

   assign both_idx    = ld_found && st_found && op_is_idx(s_op[ld_pick]) && op_is_idx(s_op[st_pick]);
   assign st_is_older = age[ld_pick][st_pick];
   assign k_issue     = k_found;
   assign ld_issue    = ld_found && !(both_idx && st_is_older);
   assign st_issue    = st_found && !(both_idx && !st_is_older);

   // ---------------- completion ----------------
   logic [N-1:0] free_mask, vld_set, iss_set;

   always_comb begin
      free_mask = '0;
      if (k_done  && k_busy)  free_mask[k_done_slot]  = 1'b1;
      if (ld_done && ld_busy) free_mask[ld_done_slot] = 1'b1;
      if (st_done && st_busy) free_mask[st_done_slot] = 1'b1;
      vld_set = '0;
      if (accept) vld_set[alloc_idx] = 1'b1;
      iss_set = '0;
      if (k_issue)  iss_set[k_pick]  = 1'b1;
      if (ld_issue) iss_set[ld_pick] = 1'b1;
      if (st_issue) iss_set[st_pick] = 1'b1;
   end

   // ---------------- state update ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld         <= '0;
         iss         <= '0;
         k_busy      <= 1'b0;
         ld_busy     <= 1'b0;
         st_busy     <= 1'b0;
         ld_busy_idx <= 1'b0;
         st_busy_idx <= 1'b0;
         for (int i = 0; i < N; i++) begin
            age[i]   <= '0;
            s_op[i]  <= '0;
            s_src[i] <= '0;
            s_dst[i] <= '0;
            s_buf[i] <= '0;
         end
      end else begin
         vld <= (vld & ~free_mask) | vld_set;
         iss <= (iss & ~free_mask) | iss_set;
         for (int i = 0; i < N; i++) begin
            age[i] <= age[i] & ~free_mask;
         end
         if (accept) begin
            s_op[alloc_idx]  <= cmd_op;
            s_src[alloc_idx] <= cmd_src;
            s_dst[alloc_idx] <= cmd_dst;
            s_buf[alloc_idx] <= cmd_buf;
            age[alloc_idx]   <= vld & ~free_mask;
         end
         k_busy  <= (k_busy  && !k_done)  || k_issue;
         ld_busy <= (ld_busy && !ld_done) || ld_issue;
         st_busy <= (st_busy && !st_done) || st_issue;
         if (ld_issue) ld_busy_idx <= op_is_idx(s_op[ld_pick]);
         if (st_issue) st_busy_idx <= op_is_idx(s_op[st_pick]);
      end
   end

   // ---------------- issue registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         k_go       <= 1'b0;
         k_slot     <= '0;
         k_src      <= '0;
         k_dst      <= '0;
         ld_go      <= 1'b0;
         ld_slot    <= '0;
         ld_indexed <= 1'b0;
         ld_dst     <= '0;
         ld_buf     <= '0;
         st_go      <= 1'b0;
         st_slot    <= '0;
         st_indexed <= 1'b0;
         st_src     <= '0;
         st_buf     <= '0;
      end else begin
         k_go  <= k_issue;
         ld_go <= ld_issue;
         st_go <= st_issue;
         if (k_issue) begin
            k_slot <= k_pick;
            k_src  <= s_src[k_pick];
            k_dst  <= s_dst[k_pick];
         end
         if (ld_issue) begin
            ld_slot    <= ld_pick;
            ld_indexed <= op_is_idx(s_op[ld_pick]);
            ld_dst     <= s_dst[ld_pick];
            ld_buf     <= s_buf[ld_pick];
         end
         if (st_issue) begin
            st_slot    <= st_pick;
            st_indexed <= op_is_idx(s_op[st_pick]);
            st_src     <= s_src[st_pick];
            st_buf     <= s_buf[st_pick];
         end
      end
   end

   // ---------------- assertions ----------------
   a_r2_mem_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op_is_mem(cmd_op) && !cmd_ready) |-> (&vld[MEM_SLOTS-1:0]))
      else $error("R2: memory write stalled with a free memory slot");

   a_r9_one_indexed: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_busy && ld_busy_idx && st_busy && st_busy_idx))
      else $error("R9: two indexed transfers in flight");

   a_r10_kern_single: assert property (@(posedge clk) disable iff (!rst_n)
      k_go |-> !$past(k_busy))
      else $error("R10: kernel issued while the kernel unit was busy");

   a_r10_go_slot_live: assert property (@(posedge clk) disable iff (!rst_n)
      ld_go |-> (vld[ld_slot] && iss[ld_slot]))
      else $error("R10: load issue pulse for a slot that is not live");

   a_r11_k_done_tag: assert property (@(posedge clk) disable iff (!rst_n)
      k_done |-> (k_busy && k_done_slot == k_slot))
      else $error("R11: kernel done with no kernel in flight or wrong slot");

   a_r11_ld_done_tag: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done |-> (ld_busy && ld_done_slot == ld_slot))
      else $error("R11: load done with no load in flight or wrong slot");

   a_r11_st_done_tag: assert property (@(posedge clk) disable iff (!rst_n)
      st_done |-> (st_busy && st_done_slot == st_slot))
      else $error("R11: store done with no store in flight or wrong slot");

endmodule

// File: tb/stream_dep_sched_bench.sv
module stream_dep_sched_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [2:0] cmd_op = '0;
   logic [3:0] cmd_src = '0, cmd_dst = '0, cmd_buf = '0;
   logic       k_go, ld_go, st_go, ld_indexed, st_indexed;
   logic [3:0] k_slot, k_src, k_dst, ld_slot, ld_dst, ld_buf, st_slot, st_src, st_buf;
   logic       k_done = 1'b0, ld_done = 1'b0, st_done = 1'b0;
   logic [3:0] k_done_slot = '0, ld_done_slot = '0, st_done_slot = '0;

   stream_dep_sched u_stream_dep_sched (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_buf(cmd_buf),
      .k_go(k_go), .k_slot(k_slot), .k_src(k_src), .k_dst(k_dst),
      .k_done(k_done), .k_done_slot(k_done_slot),
      .ld_go(ld_go), .ld_slot(ld_slot), .ld_indexed(ld_indexed), .ld_dst(ld_dst), .ld_buf(ld_buf),
      .ld_done(ld_done), .ld_done_slot(ld_done_slot),
      .st_go(st_go), .st_slot(st_slot), .st_indexed(st_indexed), .st_src(st_src), .st_buf(st_buf),
      .st_done(st_done), .st_done_slot(st_done_slot)
   );

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 1'b0;
   int k_lat = 3, l_lat = 3, s_lat = 3;
   bit k_hold = 1'b0, l_hold = 1'b0;
   int exp_k[$], exp_l[$], exp_s[$];
   int go_at[int], done_at[int];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int key_of(input logic [2:0] op, input logic [3:0] s, input logic [3:0] d,
                                 input logic [3:0] b);
      return {17'd0, op, s, d, b};
   endfunction

   function automatic int gat(input int k);
      return go_at.exists(k) ? go_at[k] : -1;
   endfunction

   function automatic int dat(input int k);
      return done_at.exists(k) ? done_at[k] : -1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic sb_pop(inout int q[$], input int key, input string chan);
      if (q.size() == 0) chk(1'b0, "R10", {chan, " unexpected issue"}, key, -1);
      else begin
         int e;
         e = q.pop_front();
         chk(e == key, "R10", {chan, " issue order"}, key, e);
      end
   endtask

   // kernel responder and monitor
   initial begin
      logic [3:0] sl;
      int kk;
      forever begin
         @(negedge clk);
         if (k_go) begin
            sl = k_slot;
            kk = key_of(3'd4, k_src, k_dst, 4'd0);
            go_at[kk] = cyc;
            sb_pop(exp_k, kk, "kernel");
            repeat (k_lat) @(negedge clk);
            while (k_hold) @(negedge clk);
            k_done = 1'b1; k_done_slot = sl; done_at[kk] = cyc + 1;
            @(negedge clk);
            k_done = 1'b0;
         end
      end
   end

   // load responder and monitor
   initial begin
      logic [3:0] sl;
      int kk;
      forever begin
         @(negedge clk);
         if (ld_go) begin
            sl = ld_slot;
            kk = key_of(ld_indexed ? 3'd2 : 3'd0, 4'd0, ld_dst, ld_buf);
            go_at[kk] = cyc;
            sb_pop(exp_l, kk, "load");
            repeat (l_lat) @(negedge clk);
            while (l_hold) @(negedge clk);
            ld_done = 1'b1; ld_done_slot = sl; done_at[kk] = cyc + 1;
            @(negedge clk);
            ld_done = 1'b0;
         end
      end
   end

   // store responder and monitor
   initial begin
      logic [3:0] sl;
      int kk;
      forever begin
         @(negedge clk);
         if (st_go) begin
            sl = st_slot;
            kk = key_of(st_indexed ? 3'd3 : 3'd1, st_src, 4'd0, st_buf);
            go_at[kk] = cyc;
            sb_pop(exp_s, kk, "store");
            repeat (s_lat) @(negedge clk);
            st_done = 1'b1; st_done_slot = sl; done_at[kk] = cyc + 1;
            @(negedge clk);
            st_done = 1'b0;
         end
      end
   end

   task automatic expect_go(input logic [2:0] op, input logic [3:0] s, input logic [3:0] d,
                            input logic [3:0] b);
      int kk;
      kk = key_of(op, s, d, b);
      if (op == 3'd4) exp_k.push_back(kk);
      else if (op == 3'd0 || op == 3'd2) exp_l.push_back(kk);
      else exp_s.push_back(kk);
   endtask

   // driver: called at a negedge; returns at the negedge after acceptance
   task automatic push(input logic [2:0] op, input logic [3:0] s, input logic [3:0] d,
                       input logic [3:0] b, input bit enq);
      if (enq) expect_go(op, s, d, b);
      cmd_op = op; cmd_src = s; cmd_dst = d; cmd_buf = b; cmd_valid = 1'b1;
      #1;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_k.size() + exp_l.size() + exp_s.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "R10", "watchdog expired", cyc, 0);
      summary();
   end

   initial begin
      int kl1, kk1, ks1, kl2, kk2, ks2, kbl, kbs, kil, kis, kka, kkb;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cmd_op = 3'd0; #1;
      chk(cmd_ready == 1'b1, "R1", "ready for block load after reset", cmd_ready, 1);
      cmd_op = 3'd4; #1;
      chk(cmd_ready == 1'b1, "R1", "ready for kernel after reset", cmd_ready, 1);
      cmd_op = 3'd6; #1;
      chk(cmd_ready == 1'b0, "R1", "illegal opcode not accepted", cmd_ready, 0);
      chk({k_go, ld_go, st_go} == 3'b000, "R1", "no issue after reset", {k_go, ld_go, st_go}, 0);
      @(negedge clk);

      // chain: load -> kernel -> store -> load on same buffer
      l_lat = 4; s_lat = 4; k_lat = 3;
      push(3'd0, 4'd0, 4'd1, 4'd1, 1'b1);
      push(3'd4, 4'd1, 4'd2, 4'd0, 1'b1);
      push(3'd1, 4'd2, 4'd0, 4'd1, 1'b1);
      push(3'd0, 4'd0, 4'd1, 4'd1, 1'b1);
      kl1 = key_of(3'd0, 0, 1, 1); kk1 = key_of(3'd4, 1, 2, 0); ks1 = key_of(3'd1, 2, 0, 1);
      // the second load has the same key; record the first load's times before it runs
      while (!done_at.exists(kl1)) @(negedge clk);
      kl2 = dat(kl1);
      while (!go_at.exists(kk1)) @(negedge clk);
      chk(gat(kk1) > kl2, "R3", "kernel after load of its source", gat(kk1), kl2 + 1);
      chk(gat(kk1) == kl2 + 1, "R11", "kernel issue one cycle after done", gat(kk1), kl2 + 1);
      drain();
      chk(gat(ks1) > dat(kk1), "R5", "store after producing kernel", gat(ks1), dat(kk1) + 1);
      chk(gat(kl1) > dat(kk1), "R6", "second load after reading kernel", gat(kl1), dat(kk1) + 1);
      chk(gat(kl1) > dat(ks1), "R7", "second load after store to same buffer", gat(kl1), dat(ks1) + 1);

      // R4: kernel waits for store reading its destination
      s_lat = 8;
      push(3'd1, 4'd3, 4'd0, 4'd2, 1'b1);
      push(3'd4, 4'd4, 4'd3, 4'd0, 1'b1);
      drain();
      ks2 = key_of(3'd1, 3, 0, 2); kk2 = key_of(3'd4, 4, 3, 0);
      chk(gat(kk2) > dat(ks2), "R4", "kernel after store of its destination", gat(kk2), dat(ks2) + 1);

      // R8: independent block load and store overlap
      l_lat = 10; s_lat = 10;
      push(3'd0, 4'd0, 4'd5, 4'd5, 1'b1);
      push(3'd1, 4'd6, 4'd0, 4'd6, 1'b1);
      drain();
      kbl = key_of(3'd0, 0, 5, 5); kbs = key_of(3'd1, 6, 0, 6);
      chk(gat(kbs) < dat(kbl), "R8", "store starts before load ends", gat(kbs), dat(kbl) - 1);
      chk(gat(kbl) < dat(kbs), "R8", "load starts before store ends", gat(kbl), dat(kbs) - 1);

      // R9: indexed transfers serialized
      l_lat = 6; s_lat = 6;
      push(3'd2, 4'd0, 4'd7, 4'd7, 1'b1);
      push(3'd3, 4'd8, 4'd0, 4'd8, 1'b1);
      drain();
      kil = key_of(3'd2, 0, 7, 7); kis = key_of(3'd3, 8, 0, 8);
      chk(gat(kis) > dat(kil), "R9", "indexed store after indexed load", gat(kis), dat(kil) + 1);

      // R10: younger ready kernel bypasses blocked older one; loads issue oldest first
      l_lat = 12; k_lat = 2;
      expect_go(3'd4, 4'd11, 4'd12, 4'd0);
      expect_go(3'd4, 4'd9, 4'd10, 4'd0);
      push(3'd0, 4'd0, 4'd9, 4'd9, 1'b1);
      push(3'd4, 4'd9, 4'd10, 4'd0, 1'b0);
      push(3'd4, 4'd11, 4'd12, 4'd0, 1'b0);
      push(3'd0, 4'd0, 4'd13, 4'd13, 1'b1);
      push(3'd0, 4'd0, 4'd14, 4'd14, 1'b1);
      push(3'd0, 4'd0, 4'd15, 4'd15, 1'b1);
      drain();
      kka = key_of(3'd4, 9, 10, 0); kkb = key_of(3'd4, 11, 12, 0);
      chk(gat(kkb) < gat(kka), "R10", "younger independent kernel first", gat(kkb), gat(kka) - 1);

      // R2: fill the memory pool while the first load is held
      l_lat = 1; l_hold = 1'b1;
      for (int i = 0; i < 12; i++) push(3'd0, 4'd0, 4'(i), 4'(i), 1'b1);
      cmd_op = 3'd0; #1;
      chk(cmd_ready == 1'b0, "R2", "memory pool full stalls load", cmd_ready, 0);
      cmd_op = 3'd1; #1;
      chk(cmd_ready == 1'b0, "R2", "memory pool full stalls store", cmd_ready, 0);
      cmd_op = 3'd4; #1;
      chk(cmd_ready == 1'b1, "R2", "kernel pool open with memory full", cmd_ready, 1);
      @(negedge clk);
      fork
         push(3'd0, 4'd0, 4'd12, 4'd12, 1'b1);
      join_none
      repeat (5) @(negedge clk);
      chk(cmd_ready == 1'b0, "R2", "thirteenth write still waiting", cmd_ready, 0);
      l_hold = 1'b0;
      drain();
      chk(go_at.exists(key_of(3'd0, 0, 12, 12)), "R11", "freed slot reused by waiting write",
          go_at.exists(key_of(3'd0, 0, 12, 12)), 1);

      // R2: kernel pool fills independently
      k_hold = 1'b1;
      for (int i = 0; i < 4; i++) push(3'd4, 4'(i), 4'(i + 4), 4'd0, 1'b1);
      cmd_op = 3'd4; #1;
      chk(cmd_ready == 1'b0, "R2", "kernel pool full stalls kernel", cmd_ready, 0);
      cmd_op = 3'd0; #1;
      chk(cmd_ready == 1'b1, "R2", "memory pool open with kernels full", cmd_ready, 1);
      k_hold = 1'b0;
      @(negedge clk);
      drain();

      summary();
   end

endmodule